// File: doc/BRIEF.md
# Local Serial Stream Pin Multiplexer

The block carries four logical local streams, each 32 channels of 8 bits per 125 µs frame, over four serial output pins and four serial input pins. A 2-bit run-time mode field selects how the streams are packed onto the pins. In one mode each stream has its own pin at the base rate. In another, pairs of streams share a pin at twice the base rate. In a third, all four streams share one pin at four times the rate. The fourth mode is mixed: two pins run at the base rate and a third pin carries a pair of streams at twice the rate. On shared pins, channel bytes from the member streams are interleaved one byte at a time.

The block runs on a single clock whose period is one bit time at the fastest pin rate, so 1024 clock cycles make one frame. On the transmit side it asks for each channel byte one cycle before that byte's slot begins, tagged with stream and channel, and shifts the byte out MSB first. On the receive side it samples each input pin at mid-bit, reassembles bytes and presents each one with its stream and channel tags. A newly written mode is adopted only at the next frame boundary.

Top module: `lsm_serial_mux`

## Requirements
- R1: Mode 0: each stream s uses pin s at 4 clocks per bit, and each pin carries 32 slots per frame of one stream, channel n in slot n.
- R2: Mode 1: 2 clocks per bit; streams 0 and 1 share pin 0, and streams 2 and 3 share pin 2, 64 slots per pin.
- R3: Mode 2: 1 clock per bit; all four streams share pin 0, 128 slots per frame.
- R4: Mode 3: streams 0 and 1 use pins 0 and 1 at 4 clocks per bit, and streams 2 and 3 share pin 2 at 2 clocks per bit.
- R5: On a pin shared by k streams whose lowest stream is b, slot j carries stream b + (j mod k), channel j / k; tx_chan reports that channel.
- R6: tx_req[s] pulses for one cycle in the cycle before the slot starts, and tx_data[8s+7:8s] is taken at the next clock edge. The byte leaves MSB first, with the pin changing only at the clock edge that starts each bit period.
- R7: Each input pin in use is sampled in bit-period cycle d/2, where d is the clocks per bit (cycle 0 when d is 1). After the eighth sample, rx_valid[s] pulses for one cycle with the byte in rx_data[8s+7:8s] (first bit in bit 7) and its channel in rx_chan[5s+4:5s].
- R8: Output pins that are not in use in the current mode are held at 0, and input pins that are not in use produce no received bytes.
- R9: A frame is 1024 clocks long, and stream 0 channel 0 always opens it. A mode_sel value is adopted only at the next frame start; the value present in the last cycle of a frame governs the whole next frame.
- R10: While reset is asserted, every ser_out pin is 0, and no tx_req or rx_valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per bit at the fastest pin rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Requested pin configuration, 0 to 3 |
| tx_req | output | 4 | Per-stream request for the next channel byte |
| tx_chan | output | 20 | Channel number of each requested byte, 5 bits per stream |
| tx_data | input | 32 | Channel byte for each requesting stream, 8 bits per stream |
| ser_out | output | 4 | Serial output pins |
| ser_in | input | 4 | Serial input pins |
| rx_valid | output | 4 | Per-stream received byte strobe |
| rx_chan | output | 20 | Channel number of each received byte, 5 bits per stream |
| rx_data | output | 32 | Received byte for each stream, 8 bits per stream |

## Verification
Two things can fall in the same clock cycle. One is the frame-boundary mode change. The other is the completion of the last receive byte, and at the same time the first transmit request, under the old and the new configuration. The bench loops the output pins back to the input pins and changes the mode several times in the middle of a frame, twice within one frame, so that the receive of the final slot and the request for slot zero of the next layout meet on the same edge. It injects noise on the input pins that are idle. A scoreboard then judges the result: per-stream queues must pop in order with matching channel and data, and each pin must show, bit by bit, the byte the bench supplied under the layout it derived for that frame.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int NPIN          = 4;
  localparam int CH_PER_STREAM = 32;
  localparam int SLOT_BITS     = 8;
  localparam int FRAME_CLKS    = NPIN * CH_PER_STREAM * SLOT_BITS;
  localparam int CW            = $clog2(FRAME_CLKS);
  localparam int CHW           = $clog2(CH_PER_STREAM);
  localparam int SW            = $clog2(NPIN);

  typedef enum logic [1:0] {
    MODE_2M       = 2'd0,
    MODE_4M_PAIRS = 2'd1,
    MODE_8M_ALL   = 2'd2,
    MODE_MIXED    = 2'd3
  } pin_mode_e;

  // lg_rate: log2 of clocks per bit; lg_share: log2 of streams per pin
  typedef struct packed {
    logic          on;
    logic [1:0]    lg_rate;
    logic [1:0]    lg_share;
    logic [SW-1:0] first;
  } lane_cfg_t;

  typedef struct packed {
    logic [1:0]     phase;
    logic [2:0]     bitn;
    logic [SW-1:0]  strm;
    logic [CHW-1:0] chan;
  } slot_pos_t;

  function automatic lane_cfg_t cfg_of(pin_mode_e m, int pin);
    lane_cfg_t g;
    g = '0;
    case (m)
      MODE_2M: begin
        g.on = 1'b1; g.lg_rate = 2'd2; g.lg_share = 2'd0; g.first = SW'(pin);
      end
      MODE_4M_PAIRS: if (pin == 0 || pin == 2) begin
        g.on = 1'b1; g.lg_rate = 2'd1; g.lg_share = 2'd1; g.first = SW'(pin);
      end
      MODE_8M_ALL: if (pin == 0) begin
        g.on = 1'b1; g.lg_rate = 2'd0; g.lg_share = 2'd2; g.first = '0;
      end
      default: begin
        if (pin < 2) begin
          g.on = 1'b1; g.lg_rate = 2'd2; g.lg_share = 2'd0; g.first = SW'(pin);
        end else if (pin == 2) begin
          g.on = 1'b1; g.lg_rate = 2'd1; g.lg_share = 2'd1; g.first = SW'(pin);
        end
      end
    endcase
    return g;
  endfunction

  function automatic logic [1:0] low_mask(logic [1:0] lg);
    return (lg == 2'd2) ? 2'b11 : (lg == 2'd1) ? 2'b01 : 2'b00;
  endfunction

  function automatic slot_pos_t pos_of(logic [CW-1:0] c, lane_cfg_t g);
    slot_pos_t     p;
    logic [CW-1:0] slot;
    slot   = c >> ({1'b0, g.lg_rate} + 3'd3);
    p.phase = c[1:0] & low_mask(g.lg_rate);
    p.bitn  = 3'(c >> g.lg_rate);
    p.strm  = g.first + (slot[SW-1:0] & low_mask(g.lg_share));
    p.chan  = CHW'(slot >> g.lg_share);
    return p;
  endfunction
endpackage

// File: rtl/lsm_frame_timer.sv
module lsm_frame_timer
  import lsm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  pin_mode_e     mode_req,
  output logic [CW-1:0] cnt_now,
  output logic [CW-1:0] cnt_next,
  output pin_mode_e     mode_now,
  output pin_mode_e     mode_next
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CLKS - 1);

  logic [CW-1:0] cnt_q;
  pin_mode_e     mode_q;
  logic          wrap;

  always_comb begin
    wrap      = (cnt_q == LAST);
    cnt_next  = wrap ? '0 : cnt_q + 1'b1;
    mode_next = wrap ? mode_req : mode_q;
  end

  // reset parks the counter on the last cycle so the first edge opens a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LAST;
      mode_q <= MODE_2M;
    end else begin
      cnt_q  <= cnt_next;
      mode_q <= mode_next;
    end
  end

  assign cnt_now  = cnt_q;
  assign mode_now = mode_q;

  a_r9_mode_held_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(mode_q));
  a_r9_frame_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/lsm_lane.sv
module lsm_lane
  import lsm_pkg::*;
#(
  parameter int PIN = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  pin_mode_e      mode_now,
  input  pin_mode_e      mode_next,
  input  logic [CW-1:0]  cnt_now,
  input  logic [CW-1:0]  cnt_next,
  output logic           req,
  output logic [SW-1:0]  req_strm,
  output logic [CHW-1:0] req_chan,
  input  logic [7:0]     tx_byte,
  output logic           sout,
  input  logic           sin,
  output logic           rx_fire,
  output logic [SW-1:0]  rx_strm,
  output logic [CHW-1:0] rx_chan,
  output logic [7:0]     rx_byte
);
  lane_cfg_t cfg_n, cfg_c;
  slot_pos_t pos_n, pos_c;
  logic      slot_start, bit_edge, samp, last_samp;
  logic [1:0] half;

  logic       sout_q, sout_d;
  logic [7:0] tsh_q, tsh_d;
  logic [6:0] rsh_q, rsh_d;
  logic       fire_q, fire_d;
  logic [7:0] rbyte_q, rbyte_d;
  logic [SW-1:0]  rstrm_q, rstrm_d;
  logic [CHW-1:0] rchan_q, rchan_d;

  always_comb begin
    cfg_n      = cfg_of(mode_next, PIN);
    cfg_c      = cfg_of(mode_now, PIN);
    pos_n      = pos_of(cnt_next, cfg_n);
    pos_c      = pos_of(cnt_now, cfg_c);
    bit_edge   = cfg_n.on && (pos_n.phase == 2'd0);
    slot_start = bit_edge && (pos_n.bitn == 3'd0);
    half       = (cfg_c.lg_rate == 2'd2) ? 2'd2 : (cfg_c.lg_rate == 2'd1) ? 2'd1 : 2'd0;
    samp       = cfg_c.on && (pos_c.phase == half);
    last_samp  = samp && (pos_c.bitn == 3'd7);
  end

  assign req      = slot_start;
  assign req_strm = pos_n.strm;
  assign req_chan = pos_n.chan;

  // transmit next state
  always_comb begin
    sout_d = sout_q;
    tsh_d  = tsh_q;
    if (!cfg_n.on) begin
      sout_d = 1'b0;
      tsh_d  = '0;
    end else if (slot_start) begin
      sout_d = tx_byte[7];
      tsh_d  = {tx_byte[6:0], 1'b0};
    end else if (bit_edge) begin
      sout_d = tsh_q[7];
      tsh_d  = {tsh_q[6:0], 1'b0};
    end
  end

  // receive next state
  always_comb begin
    rsh_d   = samp ? {rsh_q[5:0], sin} : rsh_q;
    fire_d  = last_samp;
    rbyte_d = last_samp ? {rsh_q, sin} : rbyte_q;
    rstrm_d = last_samp ? pos_c.strm : rstrm_q;
    rchan_d = last_samp ? pos_c.chan : rchan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sout_q  <= 1'b0;
      tsh_q   <= '0;
      rsh_q   <= '0;
      fire_q  <= 1'b0;
      rbyte_q <= '0;
      rstrm_q <= '0;
      rchan_q <= '0;
    end else begin
      sout_q  <= sout_d;
      tsh_q   <= tsh_d;
      rsh_q   <= rsh_d;
      fire_q  <= fire_d;
      rbyte_q <= rbyte_d;
      rstrm_q <= rstrm_d;
      rchan_q <= rchan_d;
    end
  end

  assign sout    = sout_q;
  assign rx_fire = fire_q;
  assign rx_strm = rstrm_q;
  assign rx_chan = rchan_q;
  assign rx_byte = rbyte_q;

  a_r6_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_c.on && pos_c.phase != 2'd0) |-> $stable(sout_q));
  a_r8_idle_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_c.on |-> !sout_q);
  a_r7_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
endmodule

// File: rtl/lsm_serial_mux.sv
module lsm_serial_mux
  import lsm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_sel,
  output logic [NPIN-1:0]     tx_req,
  output logic [NPIN*CHW-1:0] tx_chan,
  input  logic [NPIN*8-1:0]   tx_data,
  output logic [NPIN-1:0]     ser_out,
  input  logic [NPIN-1:0]     ser_in,
  output logic [NPIN-1:0]     rx_valid,
  output logic [NPIN*CHW-1:0] rx_chan,
  output logic [NPIN*8-1:0]   rx_data
);
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [CW-1:0] cnt_now, cnt_next;
  pin_mode_e     mode_now, mode_next;

  lsm_frame_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_i),
    .mode_req (pin_mode_e'(mode_sel)),
    .cnt_now  (cnt_now),
    .cnt_next (cnt_next),
    .mode_now (mode_now),
    .mode_next(mode_next)
  );

  logic [NPIN-1:0] ln_req, ln_fire;
  logic [SW-1:0]   ln_qs [NPIN];
  logic [CHW-1:0]  ln_qc [NPIN];
  logic [7:0]      ln_txb[NPIN];
  logic [SW-1:0]   ln_rs [NPIN];
  logic [CHW-1:0]  ln_rc [NPIN];
  logic [7:0]      ln_rb [NPIN];

  for (genvar p = 0; p < NPIN; p++) begin : g_lane
    assign ln_txb[p] = tx_data[{ln_qs[p], 3'b000} +: 8];
    lsm_lane #(.PIN(p)) u_lane (
      .clk      (clk),
      .rst_n    (rst_i),
      .mode_now (mode_now),
      .mode_next(mode_next),
      .cnt_now  (cnt_now),
      .cnt_next (cnt_next),
      .req      (ln_req[p]),
      .req_strm (ln_qs[p]),
      .req_chan (ln_qc[p]),
      .tx_byte  (ln_txb[p]),
      .sout     (ser_out[p]),
      .sin      (ser_in[p]),
      .rx_fire  (ln_fire[p]),
      .rx_strm  (ln_rs[p]),
      .rx_chan  (ln_rc[p]),
      .rx_byte  (ln_rb[p])
    );
  end

  // lane-indexed results steered onto stream-indexed ports
  always_comb begin
    tx_req   = '0;
    tx_chan  = '0;
    rx_valid = '0;
    rx_chan  = '0;
    rx_data  = '0;
    for (int s = 0; s < NPIN; s++) begin
      for (int p = 0; p < NPIN; p++) begin
        if (rst_i && ln_req[p] && ln_qs[p] == SW'(s)) begin
          tx_req[s]              = 1'b1;
          tx_chan[s*CHW +: CHW]  = ln_qc[p];
        end
        if (ln_fire[p] && ln_rs[p] == SW'(s)) begin
          rx_valid[s]            = 1'b1;
          rx_chan[s*CHW +: CHW]  = ln_rc[p];
          rx_data[s*8 +: 8]      = ln_rb[p];
        end
      end
    end
  end

  a_r3_one_stream_per_cycle: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_now == MODE_8M_ALL && cnt_now != '0) |-> $onehot0(rx_valid));
  a_r10_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (tx_req == '0 && rx_valid == '0));
endmodule

// File: tb/lsm_serial_mux_tb.sv
module lsm_serial_mux_tb;
  import lsm_pkg::*;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [1:0]          mode_sel;
  logic [NPIN-1:0]     tx_req;
  logic [NPIN*CHW-1:0] tx_chan;
  logic [NPIN*8-1:0]   tx_data;
  logic [NPIN-1:0]     ser_out;
  logic [NPIN-1:0]     ser_in;
  logic [NPIN-1:0]     rx_valid;
  logic [NPIN*CHW-1:0] rx_chan;
  logic [NPIN*8-1:0]   rx_data;

  always #4 clk = ~clk;

  lsm_serial_mux u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .tx_req(tx_req), .tx_chan(tx_chan), .tx_data(tx_data),
    .ser_out(ser_out), .ser_in(ser_in),
    .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_data(rx_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit run  = 0;

  function automatic int pin_of(int m, int s);
    case (m)
      0: return s;
      1: return (s < 2) ? 0 : 2;
      2: return 0;
      default: return (s < 2) ? s : 2;
    endcase
  endfunction
  function automatic int clk_per_bit(int m, int s);
    case (m)
      0: return 4;
      1: return 2;
      2: return 1;
      default: return (s < 2) ? 4 : 2;
    endcase
  endfunction
  function automatic int share_of(int m, int p);
    case (m)
      1: return 2;
      2: return 4;
      3: return (p == 2) ? 2 : 1;
      default: return 1;
    endcase
  endfunction
  function automatic int first_of(int m, int p);
    return (m == 2) ? 0 : p;
  endfunction
  function automatic bit pin_used(int m, int p);
    case (m)
      0: return 1'b1;
      1: return (p == 0 || p == 2);
      2: return (p == 0);
      default: return (p != 3);
    endcase
  endfunction
  function automatic string mode_tag(int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // scoreboard state
  logic [12:0] sbq [NPIN][$];
  int   eff_mode = 0;
  int   sin_mode = 0;
  bit   pend = 0;
  int   cyc = 0;
  int   last_fs = -1;
  int   fcount = 0;
  int   pslot [NPIN];
  bit   trk_on [NPIN];
  logic [7:0] trk_b [NPIN];
  int   trk_n [NPIN];
  int   trk_d [NPIN];
  logic [3:0] nz = 4'b1001;

  always_comb begin
    for (int p = 0; p < NPIN; p++)
      ser_in[p] = pin_used(sin_mode, p) ? ser_out[p] : nz[p];
  end

  // driver and monitor, both on the falling edge
  always @(negedge clk) begin
    if (run && !done) begin
      cyc++;
      // monitor: received bytes against the per-stream queues (R7, R8)
      for (int s = 0; s < NPIN; s++) begin
        if (rx_valid[s]) begin
          if (sbq[s].size() == 0) begin
            chk(1'b0, "R8", "byte received with nothing sent", s, -1);
          end else begin
            logic [12:0] it;
            logic [12:0] got;
            it  = sbq[s].pop_front();
            got = {rx_chan[s*CHW +: CHW], rx_data[s*8 +: 8]};
            chk(got == it, "R7", "received chan/data", int'(got), int'(it));
          end
        end
      end
      // pin trackers: unused pins low, used pins carry bytes MSB first
      for (int p = 0; p < NPIN; p++) begin
        if (!trk_on[p]) begin
          chk(ser_out[p] == 1'b0, "R8", "idle output pin level", int'(ser_out[p]), 0);
        end else begin
          logic eb;
          eb = trk_b[p][7 - trk_n[p] / trk_d[p]];
          chk(ser_out[p] == eb, {"R6 ", mode_tag(eff_mode)}, "pin bit", int'(ser_out[p]), int'(eb));
          trk_n[p]++;
          if (trk_n[p] == 8 * trk_d[p]) trk_on[p] = 1'b0;
        end
      end
      if (pend) begin
        sin_mode = eff_mode;
        pend = 1'b0;
      end
      // frame start: stream 0 channel 0 requested
      if (tx_req[0] && tx_chan[CHW-1:0] == '0) begin
        if (last_fs >= 0)
          chk(cyc - last_fs == FRAME_CLKS, "R9", "frame period", cyc - last_fs, FRAME_CLKS);
        last_fs  = cyc;
        eff_mode = int'(mode_sel);
        pend     = 1'b1;
        fcount++;
        for (int p = 0; p < NPIN; p++) pslot[p] = 0;
      end
      // requests: order, channel, data, expected pin
      for (int s = 0; s < NPIN; s++) begin
        if (tx_req[s]) begin
          int p, k, es, ec;
          logic [7:0] d;
          logic [CHW-1:0] ch;
          ch = tx_chan[s*CHW +: CHW];
          p  = pin_of(eff_mode, s);
          k  = share_of(eff_mode, p);
          es = first_of(eff_mode, p) + pslot[p] % k;
          ec = pslot[p] / k;
          chk(s == es, "R5", "stream order on pin", s, es);
          chk(int'(ch) == ec, "R5", "channel of slot", int'(ch), ec);
          pslot[p]++;
          d = 8'(s * 61 + int'(ch) * 7 + fcount * 13 + 5);
          tx_data[s*8 +: 8] = d;
          sbq[s].push_back({ch, d});
          trk_on[p] = 1'b1;
          trk_b[p]  = d;
          trk_n[p]  = 0;
          trk_d[p]  = clk_per_bit(eff_mode, s);
        end
      end
      nz = {nz[2:0], nz[3] ^ nz[2]} ^ 4'(cyc);
    end
  end

  task automatic set_mode(int m);
    @(posedge clk);
    #2;
    mode_sel = 2'(m);
  endtask

  initial begin
    rst_n    = 1'b0;
    mode_sel = 2'd0;
    tx_data  = '0;
    for (int p = 0; p < NPIN; p++) begin
      trk_on[p] = 1'b0; trk_b[p] = '0; trk_n[p] = 0; trk_d[p] = 1; pslot[p] = 0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(ser_out == '0, "R10", "outputs in reset", int'(ser_out), 0);
    chk(tx_req == '0, "R10", "requests in reset", int'(tx_req), 0);
    chk(rx_valid == '0, "R10", "rx strobes in reset", int'(rx_valid), 0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    run   = 1'b1;
    repeat (2200) @(posedge clk);
    set_mode(1);                       // R2 from mid-frame
    repeat (2500) @(posedge clk);
    set_mode(2);                       // R3
    repeat (2300) @(posedge clk);
    set_mode(1);                       // R9: two writes inside one frame
    repeat (100) @(posedge clk);
    set_mode(3);                       // R4: only this one must win
    repeat (2600) @(posedge clk);
    set_mode(0);                       // R1 again
    repeat (2100) @(posedge clk);
    set_mode(2);
    repeat (1500) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    chk(fcount >= 12, "R9", "frames seen", fcount, 12);
    for (int s = 0; s < NPIN; s++)
      chk(sbq[s].size() <= 2, "R7", "bytes left unreceived", sbq[s].size(), 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule